// File: doc/BRIEF.md
# Row-by-Row Pixel Readout Sequencer

This block controls the readout of a switch-matrix pixel array one row at a time. When a frame trigger arrives while the block is idle, it turns on the switch of row 0 and gives it one fixed row slot. Inside that slot it waits a settling time. It then steps a shared column-multiplexer select through all of its positions. For each position it fires one convert strobe to a bank of ADCs. After the last row slot the block returns to idle. Each ADC has several channels, and every channel fans in `MUX_DEPTH` columns. One conversion therefore digitizes `NUM_ADC*CH_PER_ADC` columns at the same moment, and `MUX_DEPTH` conversions cover the whole row. With the defaults this is 8 ADCs × 8 channels × 16 positions = 1024 columns in a 1 µs slot at 50 MHz.

The block samples the digitized results a fixed number of cycles after each strobe. It then emits them as one packed beat on a valid/last-tagged stream. Column numbers rise across the lanes of a beat and from beat to beat, and rows rise through the frame. A trigger that arrives during a frame is discarded and counted. Elaboration stops with an error when the parameters break the schedule. That happens when the settle time and all conversions do not leave at least one spare cycle in the row slot, or when rows × slot length exceeds the frame limit (8 ms at 50 MHz by default).

The state machine has five states. IDLE waits for a trigger. SETTLE holds the row switch on before the first conversion. CONVERT lasts one cycle and drives the strobe. WAIT covers the ADC latency and ends with a capture. HOLD fills the rest of the row slot. The transitions are:
- IDLE→SETTLE when a trigger is accepted.
- SETTLE→CONVERT when the settle time is over.
- CONVERT→WAIT always.
- WAIT→CONVERT at a capture that is not the last one of the row.
- WAIT→HOLD at the last capture of the row.
- HOLD→SETTLE at the end of a slot that is not the last row.
- HOLD→IDLE at the end of the last row's slot.

Top module: `row_readout_seq`

## Requirements
- R1: While reset is asserted and after it is released, all row selects, the strobe, `out_valid`, `out_last` and `overrun_count` are zero until a trigger is accepted.
- R2: A trigger seen at a clock edge while idle makes `row_sel[0]` active from the next cycle. Row r is then selected for exactly `CLKS_PER_ROW` consecutive cycles, and rows follow one another in ascending order with no gap.
- R3: At most one bit of `row_sel` is set at any time, and none is set while idle.
- R4: Within each row slot (slot cycle 0 = first cycle the row is selected), `conv_strobe` pulses for one cycle at slot cycle `SETTLE_CLKS + g*(CONV_LAT+1)` for g = 0..`MUX_DEPTH`-1, and `mux_sel` equals g during strobe g. There are no other strobes.
- R5: `adc_data` is sampled in the cycle exactly `CONV_LAT` cycles after a strobe. The result appears as a one-cycle `out_valid` beat in the following cycle.
- R6: `adc_data` lane k (bits `k*SAMPLE_W +: SAMPLE_W`) belongs to ADC k/`CH_PER_ADC`, channel k%`CH_PER_ADC`. In the beat for position g, lane k carries column `g*NUM_ADC*CH_PER_ADC + k` of the current row, unchanged.
- R7: `out_last` is 1 only on the beat for the final mux position of the final row, and 0 otherwise.
- R8: A trigger seen at an edge while a frame is in progress does not change the readout timing. It raises `overrun_count` by one, and the count saturates at its maximum value.
- R9: After the last row slot the block is idle, and a new trigger starts a fresh frame at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_trig | input | 1 | Frame start request |
| adc_data | input | NUM_ADC*CH_PER_ADC*SAMPLE_W | Samples of all ADC channels, one lane per channel |
| row_sel | output | NUM_ROWS | One-hot row switch enables |
| mux_sel | output | $clog2(MUX_DEPTH) | Column multiplexer position shared by all channels |
| conv_strobe | output | 1 | ADC convert pulse |
| out_valid | output | 1 | Output beat valid |
| out_last | output | 1 | Final beat of the frame |
| out_data | output | NUM_ADC*CH_PER_ADC*SAMPLE_W | Packed samples, lane k = column g*NUM_ADC*CH_PER_ADC+k |
| overrun_count | output | OVR_W | Saturating count of ignored triggers |

## Verification
The row selects change one cycle after the edge that accepts a trigger. Strobe g of a row falls `SETTLE_CLKS + g*(CONV_LAT+1)` cycles into that row's slot. Its beat is valid `CONV_LAT+1` cycles after the strobe, and the overrun count moves one cycle after the edge that saw the ignored trigger. The bench keeps a frame-cycle counter that advances at each rising edge from the trigger input alone. From that counter it derives the due cycle of every select, strobe, beat and count value, and compares them with the outputs at every falling edge. The ADC stub returns a sample only in the cycle `CONV_LAT` after its strobe and returns junk at all other times. A capture in the wrong cycle therefore shows up as wrong data.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CONVERT,
        ST_WAIT,
        ST_HOLD
    } rd_state_e;
endpackage

// File: rtl/rrs_slot_timer.sv
module rrs_slot_timer #(
    parameter int NUM_ROWS     = 1024,
    parameter int CLKS_PER_ROW = 50,
    localparam int T_W         = $clog2(CLKS_PER_ROW),
    localparam int ROW_W       = $clog2(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             busy,
    output logic [T_W-1:0]   slot_t,
    output logic [ROW_W-1:0] row_idx,
    output logic             row_end,
    output logic             last_row
);
    logic [T_W-1:0]   t_q;
    logic [ROW_W-1:0] row_q;

    assign row_end  = (t_q == T_W'(CLKS_PER_ROW - 1));
    assign last_row = (row_q == ROW_W'(NUM_ROWS - 1));
    assign slot_t   = t_q;
    assign row_idx  = row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q   <= '0;
            row_q <= '0;
        end else if (start) begin
            t_q   <= '0;
            row_q <= '0;
        end else if (busy) begin
            if (row_end) begin
                t_q <= '0;
                if (!last_row) begin
                    row_q <= row_q + 1'b1;
                end
            end else begin
                t_q <= t_q + 1'b1;
            end
        end
    end

    // R2: a completed slot that is not the last moves on to the next row
    p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && row_end && !last_row) |=> (row_idx == $past(row_idx) + 1'b1));
endmodule

// File: rtl/rrs_fsm.sv
module rrs_fsm
    import rrs_pkg::*;
#(
    parameter int MUX_DEPTH   = 16,
    parameter int CONV_LAT    = 1,
    parameter int SETTLE_CLKS = 8,
    parameter int T_W         = 6,
    localparam int MUX_W      = $clog2(MUX_DEPTH),
    localparam int WAIT_W     = $clog2(CONV_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [T_W-1:0]   slot_t,
    input  logic             row_end,
    input  logic             last_row,
    output logic             busy,
    output logic             start,
    output logic             conv_strobe,
    output logic             capture,
    output logic             cap_last,
    output logic [MUX_W-1:0] mux_sel
);
    rd_state_e          state_q, state_d;
    logic [MUX_W-1:0]   grp_q;
    logic [WAIT_W-1:0]  wcnt_q;
    logic               settle_done;
    logic               wait_done;
    logic               grp_final;

    assign settle_done = (slot_t == T_W'(SETTLE_CLKS - 1));
    assign wait_done   = (wcnt_q == WAIT_W'(CONV_LAT - 1));
    assign grp_final   = (grp_q == MUX_W'(MUX_DEPTH - 1));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (trig)        state_d = ST_SETTLE;
            ST_SETTLE:  if (settle_done) state_d = ST_CONVERT;
            ST_CONVERT:                  state_d = ST_WAIT;
            ST_WAIT:    if (wait_done)   state_d = grp_final ? ST_HOLD : ST_CONVERT;
            ST_HOLD:    if (row_end)     state_d = last_row ? ST_IDLE : ST_SETTLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // mux position and latency counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= '0;
            wcnt_q <= '0;
        end else begin
            if (state_q == ST_CONVERT) begin
                wcnt_q <= '0;
            end else if (state_q == ST_WAIT) begin
                wcnt_q <= wcnt_q + 1'b1;
            end
            if ((state_q == ST_IDLE) || (state_q == ST_HOLD && row_end)) begin
                grp_q <= '0;
            end else if (state_q == ST_WAIT && wait_done && !grp_final) begin
                grp_q <= grp_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = 1'b1;
        start       = 1'b0;
        conv_strobe = 1'b0;
        capture     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy  = 1'b0;
                start = trig;
            end
            ST_CONVERT: conv_strobe = 1'b1;
            ST_WAIT:    capture     = wait_done;
            ST_SETTLE, ST_HOLD: ;
            default:    busy        = 1'b0;
        endcase
        cap_last = capture && grp_final && last_row;
        mux_sel  = grp_q;
    end

    // R4: no strobe before the settle time of the slot has elapsed
    p_settle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slot_t < T_W'(SETTLE_CLKS)) |-> !conv_strobe);
    // R4: a strobe lasts exactly one cycle
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> !conv_strobe);
    // R4: all conversions end before the slot does (budget holds at run time)
    p_slot_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && row_end) |-> (state_q == ST_HOLD));
    // R5: a capture never coincides with a strobe
    p_capture_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !conv_strobe);
endmodule

// File: rtl/rrs_capture.sv
module rrs_capture #(
    parameter int DATA_W = 768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              cap_last,
    input  logic [DATA_W-1:0] adc_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= capture;
            out_last  <= cap_last;
            if (capture) begin
                out_data <= adc_data;
            end
        end
    end

    // R7: last is only ever raised on a valid beat
    p_last_on_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R5: each beat is a single cycle
    p_beat_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/rrs_overrun.sv
module rrs_overrun #(
    parameter int OVR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             trig,
    output logic [OVR_W-1:0] count
);
    logic at_max;
    assign at_max = (count == {OVR_W{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (busy && trig && !at_max) begin
            count <= count + 1'b1;
        end
    end

    // R8: the count only moves on a trigger during a frame
    p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && trig) |=> (count == $past(count)));
    // R8: the count never wraps
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count >= $past(count));
endmodule

// File: rtl/row_readout_seq.sv
module row_readout_seq #(
    parameter int NUM_ROWS       = 1024,
    parameter int NUM_ADC        = 8,
    parameter int CH_PER_ADC     = 8,
    parameter int MUX_DEPTH      = 16,
    parameter int SAMPLE_W       = 12,
    parameter int CLKS_PER_ROW   = 50,
    parameter int SETTLE_CLKS    = 8,
    parameter int CONV_LAT       = 1,
    parameter int FRAME_MAX_CLKS = 400000,
    parameter int OVR_W          = 16,
    localparam int NUM_CHAN      = NUM_ADC * CH_PER_ADC,
    localparam int DATA_W        = NUM_CHAN * SAMPLE_W,
    localparam int MUX_W         = $clog2(MUX_DEPTH),
    localparam int T_W           = $clog2(CLKS_PER_ROW),
    localparam int ROW_W         = $clog2(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_trig,
    input  logic [DATA_W-1:0] adc_data,
    output logic [NUM_ROWS-1:0] row_sel,
    output logic [MUX_W-1:0]  mux_sel,
    output logic              conv_strobe,
    output logic              out_valid,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data,
    output logic [OVR_W-1:0]  overrun_count
);
    localparam int SCHED_CLKS = SETTLE_CLKS + MUX_DEPTH * (CONV_LAT + 1);
    localparam int FRAME_CLKS = NUM_ROWS * CLKS_PER_ROW;

    if (SCHED_CLKS >= CLKS_PER_ROW) begin : g_bad_slot
        $error("row schedule of %0d cycles leaves no spare cycle in a %0d-cycle slot",
               SCHED_CLKS, CLKS_PER_ROW);
    end
    if (FRAME_CLKS > FRAME_MAX_CLKS) begin : g_bad_frame
        $error("frame of %0d cycles exceeds limit %0d", FRAME_CLKS, FRAME_MAX_CLKS);
    end
    if (SETTLE_CLKS < 1 || CONV_LAT < 1 || MUX_DEPTH < 2 || NUM_ROWS < 2) begin : g_bad_min
        $error("settle, latency, mux depth and row count have minimum values");
    end

    logic             busy, start, capture, cap_last;
    logic             row_end, last_row;
    logic [T_W-1:0]   slot_t;
    logic [ROW_W-1:0] row_idx;

    rrs_slot_timer #(
        .NUM_ROWS     (NUM_ROWS),
        .CLKS_PER_ROW (CLKS_PER_ROW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .slot_t   (slot_t),
        .row_idx  (row_idx),
        .row_end  (row_end),
        .last_row (last_row)
    );

    rrs_fsm #(
        .MUX_DEPTH   (MUX_DEPTH),
        .CONV_LAT    (CONV_LAT),
        .SETTLE_CLKS (SETTLE_CLKS),
        .T_W         (T_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (frame_trig),
        .slot_t      (slot_t),
        .row_end     (row_end),
        .last_row    (last_row),
        .busy        (busy),
        .start       (start),
        .conv_strobe (conv_strobe),
        .capture     (capture),
        .cap_last    (cap_last),
        .mux_sel     (mux_sel)
    );

    rrs_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .cap_last  (cap_last),
        .adc_data  (adc_data),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_data  (out_data)
    );

    rrs_overrun #(
        .OVR_W (OVR_W)
    ) u_overrun (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .trig  (frame_trig),
        .count (overrun_count)
    );

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign row_sel[r] = busy && (row_idx == ROW_W'(r));
    end

    // R3: never more than one row switch on
    p_row_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel));
    // R3: a row is on exactly while a strobe or capture can happen
    p_row_cover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> ($countones(row_sel) == 1));
endmodule

// File: tb/tb_row_readout_seq.sv
module tb_row_readout_seq;
    localparam int NR    = 4;
    localparam int NADC  = 2;
    localparam int CPA   = 2;
    localparam int NCH   = NADC * CPA;
    localparam int MUX   = 4;
    localparam int SW    = 8;
    localparam int CPR   = 16;
    localparam int SET   = 3;
    localparam int LAT   = 2;
    localparam int OVR_W = 3;
    localparam int DW    = NCH * SW;
    localparam int FRAME = NR * CPR;
    localparam int OVR_MAX = (1 << OVR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_trig = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic [NR-1:0] row_sel;
    logic [1:0]    mux_sel;
    logic          conv_strobe, out_valid, out_last;
    logic [DW-1:0] out_data;
    logic [OVR_W-1:0] overrun_count;

    always #10 clk = ~clk;  // 50 MHz

    row_readout_seq #(
        .NUM_ROWS(NR), .NUM_ADC(NADC), .CH_PER_ADC(CPA), .MUX_DEPTH(MUX),
        .SAMPLE_W(SW), .CLKS_PER_ROW(CPR), .SETTLE_CLKS(SET), .CONV_LAT(LAT),
        .FRAME_MAX_CLKS(1000), .OVR_W(OVR_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .frame_trig(frame_trig), .adc_data(adc_data),
        .row_sel(row_sel), .mux_sel(mux_sel), .conv_strobe(conv_strobe),
        .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
        .overrun_count(overrun_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    int seed = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] pix(int row, int col, int s);
        return SW'(row * 29 + col * 7 + s);
    endfunction

    function automatic logic [DW-1:0] beat(int row, int g, int s);
        logic [DW-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*SW +: SW] = pix(row, g * NCH + k, s);
        return v;
    endfunction

    // ADC stub: result valid only LAT cycles after the strobe
    logic          p_v = 1'b0;
    logic [DW-1:0] p_d = '0;
    always @(posedge clk) begin
        int r;
        r = 0;
        for (int i = 0; i < NR; i++) if (row_sel[i]) r = i;
        cyc <= cyc + 1;
        p_v <= conv_strobe;
        p_d <= beat(r, int'(mux_sel), seed);
        adc_data <= p_v ? p_d : DW'(cyc * 13 + 101);
    end

    // reference model: frame cycle counter driven only by the trigger
    int fc = -1;
    int pfc = -1;
    int ovr = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            fc = -1; pfc = -1; ovr = 0;
        end else begin
            pfc = fc;
            if (fc >= 0) begin
                if (frame_trig && ovr < OVR_MAX) ovr++;
                fc++;
                if (fc == FRAME) fc = -1;
            end else if (frame_trig) begin
                fc = 0;
            end
        end
    end

    always @(negedge clk) begin
        int t, tp, g;
        logic [NR-1:0] rs_exp;
        logic st_exp, v_exp;
        if (rst_n && !done) begin
            rs_exp = (fc >= 0) ? NR'(1) << (fc / CPR) : '0;
            chk("R2 row select", 64'(row_sel), 64'(rs_exp));
            chk("R3 at most one row", 64'($onehot0(row_sel)), 64'(1));
            if (fc < 0) chk("R3 none idle", 64'(row_sel), 64'(0));
            t = (fc >= 0) ? fc % CPR : -1;
            st_exp = (t >= SET) && ((t - SET) % (LAT + 1) == 0) && ((t - SET) / (LAT + 1) < MUX);
            chk("R4 strobe", 64'(conv_strobe), 64'(st_exp));
            if (st_exp) chk("R4 mux select", 64'(mux_sel), 64'((t - SET) / (LAT + 1)));
            tp = (pfc >= 0) ? pfc % CPR : -1;
            g  = (tp >= SET) ? (tp - SET) / (LAT + 1) : 0;
            v_exp = (tp >= SET) && ((tp - SET) % (LAT + 1) == LAT) && (g < MUX);
            chk("R5 beat valid", 64'(out_valid), 64'(v_exp));
            if (v_exp) begin
                chk("R6 beat data", 64'(out_data), 64'(beat(pfc / CPR, g, seed)));
                chk("R7 last flag", 64'(out_last), 64'((pfc / CPR == NR - 1) && (g == MUX - 1)));
            end else begin
                chk("R7 last off", 64'(out_last), 64'(0));
            end
            chk("R8 overrun count", 64'(overrun_count), 64'(ovr));
        end
    end

    task automatic pulse();
        @(negedge clk) frame_trig = 1'b1;
        @(negedge clk) frame_trig = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1 rows in reset", 64'(row_sel), 64'(0));
        chk("R1 strobe in reset", 64'(conv_strobe), 64'(0));
        chk("R1 valid in reset", 64'({out_valid, out_last}), 64'(0));
        chk("R1 overrun in reset", 64'(overrun_count), 64'(0));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rows after reset", 64'(row_sel), 64'(0));

        // frame 1
        seed = 3;
        pulse();
        repeat (FRAME + 4) @(negedge clk);
        chk("R9 idle after frame", 64'(row_sel), 64'(0));

        // frame 2 with triggers during readout (R8), restart check (R9)
        seed = 11;
        @(negedge clk) frame_trig = 1'b1;
        @(negedge clk) frame_trig = 1'b0;
        chk("R9 restart at row 0", 64'(row_sel), 64'(1));
        repeat (20) @(negedge clk);
        pulse();
        repeat (7) @(negedge clk);
        pulse();
        repeat (FRAME) @(negedge clk);

        // trigger held high: back-to-back frames, counter saturates (R8)
        seed = 42;
        @(negedge clk) frame_trig = 1'b1;
        repeat (2 * FRAME + 10) @(negedge clk);
        frame_trig = 1'b0;
        repeat (FRAME + 4) @(negedge clk);
        chk("R8 saturated", 64'(overrun_count), 64'(OVR_MAX));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule